// File: doc/BRIEF.md
# Forwarding integer pipeline core

A five-stage in-order core (fetch, decode, read operands, execute, write) that runs a stream of register-to-register add and subtract instructions. It checks each instruction in decode against the instructions still in flight ahead of it. When a source register is still waiting on an older result, the core either takes that value from a pipeline result register or holds the instruction in decode until the value can be reached.

The elaboration parameter `FWD_MODE` selects how far forwarding reaches. In mode 0 every operand comes from the register file. In mode 1 operands can come from the write-stage result. In mode 2 they can also come from the execute-stage ALU output. For a consumer that directly follows its producer, these modes cost two, one and zero bubbles. The caller presents one instruction with `instr_valid_i` and keeps it stable while `stall_o` is high. Results leave on the register-write port in the cycle the instruction retires.

Top module: `op_fwd_core`

## Requirements
- R1: An instruction taken at a rising edge (`instr_valid_i` high, `stall_o` low) spends one cycle in each of the five stages when nothing stalls it. Two independent instructions issued back to back occupy 6 cycles in every mode, counted from the first one's fetch cycle to the second one's retire cycle, with no stall cycle.
- R2: `instr_i` bit 9 is the opcode (0 add, 1 subtract). Bits 8:6 hold the destination, bits 5:3 the first source and bits 2:0 the second source. Subtract computes first source minus second source. Results wrap modulo 2^16.
- R3: The register file has eight 16-bit registers. After reset, register k holds the value k. A result appears on `rf_we_o`/`rf_waddr_o`/`rf_wdata_o` in the cycle its instruction shows `retire_o` high, and takes effect in the register file at the end of that cycle.
- R4: Register 0 always reads 0. An instruction that targets it retires with `rf_we_o` low. Naming it as a source never causes a stall or a forward.
- R5: With `FWD_MODE`=0, a consumer directly after its producer holds in decode for 2 cycles and reads the register file in the cycle after the producer's write cycle. The pair takes 8 cycles.
- R6: With `FWD_MODE`=1, the same pair stalls 1 cycle and reads the write-stage result. The pair takes 7 cycles.
- R7: With `FWD_MODE`=2, the same pair does not stall and takes the ALU output of the producer in execute. The pair takes 6 cycles.
- R8: In every mode, the sequence of retired writes equals in-order sequential execution of the accepted program, for any spacing of dependencies.
- R9: When two in-flight instructions write the register a consumer reads, the consumer gets the younger one's result.
- R10: While stalled, fetch and decode hold their contents, a bubble enters read operands, and the input instruction is not taken. `stall_o` is high only while decode holds a valid instruction. Every accepted instruction retires exactly once, in order.
- R11: While `rst_ni` is low, `stall_o`, `retire_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | An instruction is presented on `instr_i` |
| instr_i | input | 10 | Instruction word: opcode, destination, first source, second source |
| stall_o | output | 1 | Decode holds this cycle; the presented instruction is not taken |
| retire_o | output | 1 | An instruction is in the write stage this cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 3 | Register-file write address |
| rf_wdata_o | output | 16 | Register-file write data |

## Verification
A result reaches the write port in the fifth cycle counted from its fetch cycle, plus one cycle for each stall it meets. A stall is asserted in the cycle its consumer sits in decode. The bench reads every output at the falling edge, half a cycle after the register that drives it has updated. It matches retirements to the expected write sequence by their order, not by a fixed cycle. Pair totals are measured from the edge that accepted the first instruction to the falling edge at which the second one shows `retire_o`, and are compared with 8, 7 and 6 and with the stall-cycle count of each mode.

// File: rtl/op_fwd_pkg.sv
package op_fwd_pkg;
  localparam int unsigned RA_W    = 3;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NREG    = 1 << RA_W;
  localparam int unsigned INSTR_W = 1 + 3 * RA_W;

  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
  typedef logic [RA_W-1:0]   ridx_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    op_e   op;
    ridx_t rd;
    ridx_t rs1;
    ridx_t rs2;
  } instr_t;

  typedef struct packed {
    logic   vld;
    instr_t ins;
  } slot_t;

  typedef struct packed {
    logic  vld;
    op_e   op;
    ridx_t rd;
    word_t a;
    word_t b;
  } ex_t;

  typedef struct packed {
    logic  vld;
    ridx_t rd;
    word_t res;
  } wb_t;
endpackage

// File: rtl/op_fwd_regfile.sv
module op_fwd_regfile
  import op_fwd_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ridx_t raddr_i [NRD],
  output word_t rdata_o [NRD],
  input  logic  we_i,
  input  ridx_t waddr_i,
  input  word_t wdata_i
);
  word_t rf_q [NREG];

  // register k resets to k; index 0 is never written
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          rf_q[k] <= word_t'(k);
      else if (k != 0 && we_i && waddr_i == ridx_t'(k))     rf_q[k] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = rf_q[raddr_i[r]];
  end
endmodule

// File: rtl/op_fwd_hazard.sv
module op_fwd_hazard
  import op_fwd_pkg::*;
#(
  parameter int FWD_MODE = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_t id_i,
  input  logic  rd_vld_i,
  input  ridx_t rd_dst_i,
  input  logic  ex_vld_i,
  input  ridx_t ex_dst_i,
  output logic  stall_o
);
  logic dep_rd, dep_ex;

  function automatic logic reads_reg(instr_t c, ridx_t d);
    return (d != '0) && (c.rs1 == d || c.rs2 == d);
  endfunction

  assign dep_rd = id_i.vld && rd_vld_i && reads_reg(id_i.ins, rd_dst_i);
  assign dep_ex = id_i.vld && ex_vld_i && reads_reg(id_i.ins, ex_dst_i);

  // producer one stage ahead reaches execute next cycle, two ahead reaches write
  assign stall_o = (FWD_MODE < 2 && dep_rd) || (FWD_MODE == 0 && dep_ex);

  p_r0_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i.ins.rs1 == '0 && id_i.ins.rs2 == '0) |-> !stall_o);

  if (FWD_MODE == 0) begin : g_chk_none
    p_hold_two_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dep_rd |=> stall_o);
  end
endmodule

// File: rtl/op_fwd_opsel.sv
module op_fwd_opsel
  import op_fwd_pkg::*;
#(
  parameter int FWD_MODE = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ridx_t src_i,
  input  word_t rf_i,
  input  logic  ex_vld_i,
  input  ridx_t ex_dst_i,
  input  word_t ex_val_i,
  input  logic  wb_vld_i,
  input  ridx_t wb_dst_i,
  input  word_t wb_val_i,
  output word_t val_o
);
  logic hit_ex, hit_wb;

  assign hit_ex = FWD_MODE == 2 && ex_vld_i && src_i != '0 && ex_dst_i == src_i;
  assign hit_wb = FWD_MODE >= 1 && wb_vld_i && src_i != '0 && wb_dst_i == src_i;

  // execute is the younger producer, so it wins
  assign val_o = hit_ex ? ex_val_i : (hit_wb ? wb_val_i : rf_i);

  p_zero_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (val_o == '0));
endmodule

// File: rtl/op_fwd_core.sv
module op_fwd_core
  import op_fwd_pkg::*;
#(
  parameter int FWD_MODE = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               stall_o,
  output logic               retire_o,
  output logic               rf_we_o,
  output logic [RA_W-1:0]    rf_waddr_o,
  output logic [DATA_W-1:0]  rf_wdata_o
);
  localparam int NSRC = 2;

  slot_t if_q, id_q, rd_q;
  ex_t   ex_q;
  wb_t   wb_q;
  logic  stall;
  ridx_t src     [NSRC];
  word_t rf_val  [NSRC];
  word_t opnd    [NSRC];
  word_t alu_res;

  assign src[0] = rd_q.ins.rs1;
  assign src[1] = rd_q.ins.rs2;

  op_fwd_regfile #(.NRD(NSRC)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (src),
    .rdata_o (rf_val),
    .we_i    (rf_we_o),
    .waddr_i (wb_q.rd),
    .wdata_i (wb_q.res)
  );

  op_fwd_hazard #(.FWD_MODE(FWD_MODE)) u_hz (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .id_i     (id_q),
    .rd_vld_i (rd_q.vld),
    .rd_dst_i (rd_q.ins.rd),
    .ex_vld_i (ex_q.vld),
    .ex_dst_i (ex_q.rd),
    .stall_o  (stall)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_sel
    op_fwd_opsel #(.FWD_MODE(FWD_MODE)) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src[s]),
      .rf_i     (rf_val[s]),
      .ex_vld_i (ex_q.vld),
      .ex_dst_i (ex_q.rd),
      .ex_val_i (alu_res),
      .wb_vld_i (wb_q.vld),
      .wb_dst_i (wb_q.rd),
      .wb_val_i (wb_q.res),
      .val_o    (opnd[s])
    );
  end

  always_comb begin
    if (ex_q.op == OP_SUB) alu_res = ex_q.a - ex_q.b;
    else                   alu_res = ex_q.a + ex_q.b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_q <= '0;
      id_q <= '0;
      rd_q <= '0;
      ex_q <= '0;
      wb_q <= '0;
    end else begin
      if (!stall) begin
        if_q <= '{vld: instr_valid_i, ins: instr_t'(instr_i)};
        id_q <= if_q;
        rd_q <= id_q;
      end else begin
        rd_q <= '0;  // bubble
      end
      ex_q <= '{vld: rd_q.vld, op: rd_q.ins.op, rd: rd_q.ins.rd, a: opnd[0], b: opnd[1]};
      wb_q <= '{vld: ex_q.vld, rd: ex_q.rd, res: alu_res};
    end
  end

  assign stall_o    = stall;
  assign retire_o   = wb_q.vld;
  assign rf_we_o    = wb_q.vld && wb_q.rd != '0;
  assign rf_waddr_o = wb_q.rd;
  assign rf_wdata_o = wb_q.res;

  p_stall_needs_decode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> id_q.vld);

  if (FWD_MODE < 2) begin : g_chk_ex
    p_no_stale_ex_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_q.vld |-> !(ex_q.vld && ex_q.rd != '0 &&
                     (rd_q.ins.rs1 == ex_q.rd || rd_q.ins.rs2 == ex_q.rd)));
  end
  if (FWD_MODE == 0) begin : g_chk_wb
    p_no_stale_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_q.vld |-> !(wb_q.vld && wb_q.rd != '0 &&
                     (rd_q.ins.rs1 == wb_q.rd || rd_q.ins.rs2 == wb_q.rd)));
  end
endmodule

// File: tb/op_fwd_core_bench.sv
module op_fwd_core_bench;
  import op_fwd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NMODE      = 3;
  localparam int NV         = 12;
  localparam int WD_LIMIT   = 20000;

  // {op, rd, rs1, rs2}; op 0 add, 1 subtract
  localparam logic [INSTR_W-1:0] PROG [NV] = '{
    {1'b0, 3'd1, 3'd2, 3'd3},  // r1 = r2 + r3
    {1'b1, 3'd4, 3'd1, 3'd2},  // R2 subtract order, back-to-back on first source
    {1'b0, 3'd1, 3'd4, 3'd4},  // dependent on both sources
    {1'b0, 3'd1, 3'd1, 3'd7},
    {1'b0, 3'd2, 3'd1, 3'd1},
    {1'b0, 3'd2, 3'd2, 3'd3},
    {1'b1, 3'd6, 3'd2, 3'd1},  // R9 r2 written by the two previous instructions
    {1'b0, 3'd0, 3'd6, 3'd6},  // R4 write to r0 discarded
    {1'b0, 3'd3, 3'd0, 3'd6},  // R4 r0 source while r0 write in flight
    {1'b1, 3'd7, 3'd0, 3'd3},  // R2 negative result wraps, back-to-back on second source
    {1'b0, 3'd5, 3'd7, 3'd7},  // R2 add wraps
    {1'b1, 3'd4, 3'd5, 3'd5}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic               vld_a   [NMODE];
  logic [INSTR_W-1:0] ins_a   [NMODE];
  logic               stall_w [NMODE];
  logic               ret_w   [NMODE];
  logic               we_w    [NMODE];
  logic [RA_W-1:0]    wa_w    [NMODE];
  logic [DATA_W-1:0]  wd_w    [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_dut
    op_fwd_core #(.FWD_MODE(m)) u_op_fwd_core (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .instr_valid_i (vld_a[m]),
      .instr_i       (ins_a[m]),
      .stall_o       (stall_w[m]),
      .retire_o      (ret_w[m]),
      .rf_we_o       (we_w[m]),
      .rf_waddr_o    (wa_w[m]),
      .rf_wdata_o    (wd_w[m])
    );
  end

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int act = 0;
  bit mon_on = 1'b0;
  int ret_cnt = 0;
  int stall_cnt = 0;
  int n_exp = 0;
  int ret_cyc [16];
  logic [RA_W-1:0]   exp_rd  [16];
  logic [DATA_W-1:0] exp_res [16];
  logic [DATA_W-1:0] shadow  [NREG];
  logic [DATA_W-1:0] rf_m    [NREG];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // retire monitor, sampled away from the rising edge
  always @(negedge clk_i) begin
    if (mon_on && rst_ni) begin
      if (stall_w[act]) stall_cnt++;
      if (ret_w[act]) begin
        if (ret_cnt < n_exp) begin
          if (exp_rd[ret_cnt] == '0)
            chk(!we_w[act], "R8 R4 retire to r0 without write", {we_w[act], wa_w[act], wd_w[act]}, 0);
          else
            chk(we_w[act] && wa_w[act] == exp_rd[ret_cnt] && wd_w[act] == exp_res[ret_cnt],
                "R8 retire write", {we_w[act], wa_w[act], wd_w[act]},
                {1'b1, exp_rd[ret_cnt], exp_res[ret_cnt]});
        end else begin
          chk(1'b0, "R10 extra retire", ret_cnt, n_exp);
        end
        if (we_w[act]) shadow[wa_w[act]] = wd_w[act];
        if (ret_cnt < 16) ret_cyc[ret_cnt] = cyc;
        ret_cnt++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int m = 0; m < NMODE; m++) begin
      vld_a[m] = 1'b0;
      ins_a[m] = '0;
    end
    repeat (2) @(negedge clk_i);
    for (int m = 0; m < NMODE; m++)
      chk(!stall_w[m] && !ret_w[m] && !we_w[m], "R11 reset outputs",
          {stall_w[m], ret_w[m], we_w[m]}, 0);
    ret_cnt = 0;
    stall_cnt = 0;
    for (int k = 0; k < NREG; k++) shadow[k] = DATA_W'(k);
    mon_on = 1'b1;
    rst_ni = 1'b1;
  endtask

  task automatic issue(input int m, input logic [INSTR_W-1:0] ins, output int acc);
    bit s;
    @(negedge clk_i);
    vld_a[m] = 1'b1;
    ins_a[m] = ins;
    acc = 0;
    forever begin
      s = stall_w[m];
      if (!s) acc = cyc + 1;
      @(posedge clk_i);
      if (!s) break;
      @(negedge clk_i);
    end
  endtask

  task automatic idle(input int m);
    @(negedge clk_i);
    vld_a[m] = 1'b0;
  endtask

  task automatic run_prog(input int m);
    int a_dummy;
    logic [DATA_W-1:0] va, vb, r;
    instr_t ci;
    act = m;
    do_reset();
    for (int k = 0; k < NREG; k++) rf_m[k] = DATA_W'(k);
    for (int i = 0; i < NV; i++) begin
      ci = instr_t'(PROG[i]);
      va = rf_m[ci.rs1];
      vb = rf_m[ci.rs2];
      r  = (ci.op == OP_SUB) ? va - vb : va + vb;
      if (ci.rd != '0) rf_m[ci.rd] = r;
      exp_rd[i]  = ci.rd;
      exp_res[i] = r;
    end
    n_exp = NV;
    for (int i = 0; i < NV; i++) issue(m, PROG[i], a_dummy);
    idle(m);
    repeat (15) @(negedge clk_i);
    chk(ret_cnt == NV, "R10 retire count", ret_cnt, NV);
    for (int k = 0; k < NREG; k++)
      chk(shadow[k] == rf_m[k], "R8 R3 final register", shadow[k], rf_m[k]);
  endtask

  // kind 0: dependent pair, 1: independent pair, 2: pair linked only through r0
  task automatic run_pair(input int m, input int kind);
    int acc0, acc1, tot, exp_tot, exp_st;
    logic [INSTR_W-1:0] i0, i1;
    string req;
    act = m;
    do_reset();
    case (kind)
      0: begin
        i0 = {1'b0, 3'd1, 3'd2, 3'd3}; exp_rd[0] = 3'd1; exp_res[0] = 16'd5;
        i1 = {1'b1, 3'd4, 3'd3, 3'd1}; exp_rd[1] = 3'd4; exp_res[1] = 16'hFFFE;
        exp_tot = 8 - m; exp_st = 2 - m;
        req = (m == 0) ? "R5" : (m == 1) ? "R6" : "R7";
      end
      1: begin
        i0 = {1'b0, 3'd1, 3'd2, 3'd3}; exp_rd[0] = 3'd1; exp_res[0] = 16'd5;
        i1 = {1'b1, 3'd4, 3'd3, 3'd2}; exp_rd[1] = 3'd4; exp_res[1] = 16'd1;
        exp_tot = 6; exp_st = 0; req = "R1";
      end
      default: begin
        i0 = {1'b0, 3'd0, 3'd2, 3'd3}; exp_rd[0] = 3'd0; exp_res[0] = 16'd5;
        i1 = {1'b1, 3'd4, 3'd3, 3'd0}; exp_rd[1] = 3'd4; exp_res[1] = 16'd3;
        exp_tot = 6; exp_st = 0; req = "R4";
      end
    endcase
    n_exp = 2;
    issue(m, i0, acc0);
    issue(m, i1, acc1);
    idle(m);
    repeat (12) @(negedge clk_i);
    chk(ret_cnt == 2, {req, " pair retire count"}, ret_cnt, 2);
    tot = (ret_cnt >= 2) ? ret_cyc[1] - acc0 + 1 : 0;
    chk(tot == exp_tot, {req, " pair cycle total"}, tot, exp_tot);
    chk(stall_cnt == exp_st, {req, " pair stall cycles"}, stall_cnt, exp_st);
  endtask

  task automatic run_all();
    for (int m = 0; m < NMODE; m++) run_prog(m);
    for (int m = 0; m < NMODE; m++)
      for (int k = 0; k < 3; k++) run_pair(m, k);
  endtask

  initial begin
    for (int m = 0; m < NMODE; m++) begin
      vld_a[m] = 1'b0;
      ins_a[m] = '0;
    end
    fork
      run_all();
      begin
        repeat (WD_LIMIT) @(posedge clk_i);
        chk(1'b0, "R10 watchdog expired", cyc, WD_LIMIT);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule